// File: doc/BRIEF.md
# Zero-High-Bits Execution Unit

This execution unit takes a data word and a position operand. It returns the data word with every bit at or above that position cleared. Only the low byte of the position operand counts. A position at or beyond the operand width saturates, so the data word passes through unchanged and the carry flag is raised. The unit works on 32-bit or 64-bit operands. The width comes from two control bits that the decoder has already resolved: a long-mode indication and a size-select bit.

The unit has a single register stage. It sits in an integer pipeline and accepts one operation per cycle, qualified by `in_valid`. One cycle later it presents the result, a six-bit flag vector and a flag write enable, with `out_valid` marking the cycle. If the vector-length control bit is set, the unit flags an undefined instruction. In that case the result and flag registers are not updated.

Top module: `zhb_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs go to zero on that edge, and they stay zero until the first valid operation is accepted.
- R2: The position N is `in_idx[7:0]` as an unsigned value. Bits 63:8 of `in_idx` have no effect on any output.
- R3: If N is below the active width W, result bits W-1 down to N are 0 and bits below N equal the source.
- R4: If N ≥ W, the result equals the source within W. Carry, which is `out_flags[0]`, is 1 exactly in this case and 0 otherwise.
- R5: W is 32 when `in_long` is 0, whatever the value of `in_wide`. When `in_long` is 1, W is 64 if `in_wide` is 1 and 32 if it is 0.
- R6: When W is 32, `out_result[63:32]` is zero.
- R7: Zero, which is `out_flags[1]`, is 1 when the result is all zeros. Sign, which is `out_flags[2]`, equals result bit W-1.
- R8: Overflow, aux and parity (`out_flags[3]`, `[4]` and `[5]`) are always 0.
- R9: `out_valid` is asserted exactly one cycle after a cycle in which `in_valid` is high. If no operation is accepted, `out_result` and `out_flags` hold their values.
- R10: An accepted operation with `in_vlen` set drives `out_undef` high and `out_flags_we` low in its output cycle, and leaves `out_result` and `out_flags` unchanged.
- R11: An accepted operation with `in_vlen` clear drives `out_flags_we` high and `out_undef` low in its output cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| in_src | input | 64 | Data source |
| in_idx | input | 64 | Position source (low byte used) |
| in_long | input | 1 | 64-bit mode indication |
| in_wide | input | 1 | Size select (64-bit when set in 64-bit mode) |
| in_vlen | input | 1 | Vector-length bit; nonzero is undefined |
| out_valid | output | 1 | Result cycle |
| out_result | output | 64 | Masked result |
| out_flags | output | 6 | {parity, aux, overflow, sign, zero, carry} |
| out_flags_we | output | 1 | Flags and result are to be written |
| out_undef | output | 1 | Undefined-instruction indication |

## Verification
There is only one register stage, so any fault in the mask, size or flag logic appears at the ports in the very next cycle, and the cycle-by-cycle model catches it there. A wrong hold decision for an undefined or idle cycle is harder to see. It shows up as a result or flag value that changes when it should have stayed the same, and it is visible in that same cycle. The bench mixes idle and undefined cycles between real operations so that such drift is compared against the last value that was validly written.

// File: rtl/zhb_pkg.sv
package zhb_pkg;

    localparam int FLAG_W = 6;

    typedef enum logic {
        SZ_32 = 1'b0,
        SZ_64 = 1'b1
    } zhb_size_e;

    typedef struct packed {
        logic parity;
        logic aux;
        logic ovf;
        logic sign;
        logic zero;
        logic carry;
    } zhb_flags_t;

    function automatic zhb_size_e pick_size(input logic long_mode, input logic wide);
        return (long_mode && wide) ? SZ_64 : SZ_32;
    endfunction

    function automatic int unsigned active_width(input zhb_size_e sz, input int unsigned word_w,
                                                 input int unsigned half_w);
        return (sz == SZ_64) ? word_w : half_w;
    endfunction

endpackage

// File: rtl/zhb_decode.sv
module zhb_decode
    import zhb_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             long_mode,
    input  logic             wide,
    input  logic             vlen,
    input  logic [IDX_W-1:0] idx_lo,
    output zhb_size_e        size,
    output logic [IDX_W-1:0] pos,
    output logic             undef
);
    always_comb begin
        size  = pick_size(long_mode, wide);
        pos   = idx_lo;
        undef = vlen;
    end
endmodule

// File: rtl/zhb_mask.sv
module zhb_mask
    import zhb_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int HALF_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic [WORD_W-1:0] src,
    input  logic [IDX_W-1:0]  pos,
    input  zhb_size_e         size,
    output logic [WORD_W-1:0] res,
    output logic              sat
);
    localparam int CMP_W = 32;

    logic [CMP_W-1:0]  pos_ext;
    logic [WORD_W-1:0] keep;
    logic [CMP_W-1:0]  width_now;

    assign pos_ext   = {{(CMP_W-IDX_W){1'b0}}, pos};
    assign width_now = active_width(size, WORD_W, HALF_W);

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        localparam logic [CMP_W-1:0] BIT_POS = i;
        if (i < HALF_W) begin : g_low
            assign keep[i] = pos_ext > BIT_POS;
        end else begin : g_high
            assign keep[i] = (size == SZ_64) && (pos_ext > BIT_POS);
        end
    end

    assign res = src & keep;
    assign sat = pos_ext >= width_now;
endmodule

// File: rtl/zhb_flags.sv
module zhb_flags
    import zhb_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int HALF_W = 32
) (
    input  logic [WORD_W-1:0] res,
    input  zhb_size_e         size,
    input  logic              sat,
    output zhb_flags_t        flags
);
    always_comb begin
        flags        = '0;
        flags.carry  = sat;
        flags.zero   = (res == '0);
        flags.sign   = (size == SZ_64) ? res[WORD_W-1] : res[HALF_W-1];
        flags.ovf    = 1'b0;
        flags.aux    = 1'b0;
        flags.parity = 1'b0;
    end
endmodule

// File: rtl/zhb_unit.sv
module zhb_unit
    import zhb_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int HALF_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_src,
    input  logic [WORD_W-1:0] in_idx,
    input  logic              in_long,
    input  logic              in_wide,
    input  logic              in_vlen,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic [FLAG_W-1:0] out_flags,
    output logic              out_flags_we,
    output logic              out_undef
);
    zhb_size_e         size;
    logic [IDX_W-1:0]  pos;
    logic              undef;
    logic [WORD_W-1:0] res_d;
    logic              sat;
    zhb_flags_t        flags_d;
    zhb_flags_t        flags_q;
    logic              unused_idx_hi;

    assign unused_idx_hi = ^in_idx[WORD_W-1:IDX_W];

    zhb_decode #(.IDX_W(IDX_W)) u_dec (
        .long_mode (in_long),
        .wide      (in_wide),
        .vlen      (in_vlen),
        .idx_lo    (in_idx[IDX_W-1:0]),
        .size      (size),
        .pos       (pos),
        .undef     (undef)
    );

    zhb_mask #(.WORD_W(WORD_W), .HALF_W(HALF_W), .IDX_W(IDX_W)) u_mask (
        .src  (in_src),
        .pos  (pos),
        .size (size),
        .res  (res_d),
        .sat  (sat)
    );

    zhb_flags #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_flg (
        .res   (res_d),
        .size  (size),
        .sat   (sat),
        .flags (flags_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_undef    <= 1'b0;
            out_flags_we <= 1'b0;
            out_result   <= '0;
            flags_q      <= '0;
        end else begin
            out_valid    <= in_valid;
            out_undef    <= in_valid && undef;
            out_flags_we <= in_valid && !undef;
            if (in_valid && !undef) begin
                out_result <= res_d;
                flags_q    <= flags_d;
            end
        end
    end

    assign out_flags = flags_q;
endmodule

// File: rtl/zhb_unit_chk.sv
module zhb_unit_chk #(
    parameter int WORD_W = 64,
    parameter int HALF_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_src,
    input logic              in_long,
    input logic              in_wide,
    input logic              in_vlen,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_result,
    input logic [5:0]        out_flags,
    input logic              out_flags_we,
    input logic              out_undef
);
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r10_undef_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_vlen) |=> (out_undef && !out_flags_we
                                    && $stable(out_result) && $stable(out_flags)));

    a_r11_write_enable: assert property (@(posedge clk) disable iff (rst)
        out_flags_we |-> (out_valid && !out_undef));

    a_r6_narrow_upper: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_vlen && !(in_long && in_wide))
            |=> (out_result[WORD_W-1:HALF_W] == '0));

    a_r4_saturated_copy: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_vlen && in_long && in_wide)
            |=> (out_flags[0] |-> (out_result == $past(in_src))));

    a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
        out_flags_we |-> (out_flags[1] == (out_result == '0)));

    a_r8_fixed_flags: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_flags[5:3] == 3'b000));
endmodule

bind zhb_unit zhb_unit_chk #(.WORD_W(WORD_W), .HALF_W(HALF_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_src       (in_src),
    .in_long      (in_long),
    .in_wide      (in_wide),
    .in_vlen      (in_vlen),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_flags    (out_flags),
    .out_flags_we (out_flags_we),
    .out_undef    (out_undef)
);

// File: tb/zhb_unit_test.sv
`timescale 1ns/1ps
module zhb_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_src = '0;
    logic [63:0] in_idx = '0;
    logic        in_long = 1'b0;
    logic        in_wide = 1'b0;
    logic        in_vlen = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [5:0]  out_flags;
    logic        out_flags_we;
    logic        out_undef;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_res  = '0;
    logic [5:0]  m_flg  = '0;
    logic        m_vld  = 1'b0;
    logic        m_und  = 1'b0;
    logic        m_we   = 1'b0;

    always #2 clk = ~clk;

    zhb_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src), .in_idx(in_idx),
        .in_long(in_long), .in_wide(in_wide), .in_vlen(in_vlen),
        .out_valid(out_valid), .out_result(out_result), .out_flags(out_flags),
        .out_flags_we(out_flags_we), .out_undef(out_undef)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        int w;
        int n;
        logic [63:0] r;
        if (rst) begin
            m_res = '0; m_flg = '0; m_vld = 0; m_und = 0; m_we = 0;
            return;
        end
        m_vld = in_valid;
        m_und = in_valid && in_vlen;
        m_we  = in_valid && !in_vlen;
        if (in_valid && !in_vlen) begin
            w = (in_long && in_wide) ? 64 : 32;
            n = int'(in_idx[7:0]);
            r = '0;
            for (int i = 0; i < w; i++) r[i] = (i < n) ? in_src[i] : 1'b0;
            m_res = r;
            m_flg = {3'b000, r[w-1], (r == 64'd0), (n >= w)};
        end
    endtask

    task automatic step(input string tag, input logic v, input logic [63:0] s,
                        input logic [63:0] ix, input logic lm, input logic wd,
                        input logic vl);
        in_valid = v; in_src = s; in_idx = ix; in_long = lm; in_wide = wd; in_vlen = vl;
        @(posedge clk);
        #1;
        model_update();
        check("R9", "out_valid", {63'd0, out_valid}, {63'd0, m_vld});
        check(tag, "out_result", out_result, m_res);
        check(tag, "out_flags", {58'd0, out_flags}, {58'd0, m_flg});
        check("R8", "fixed flags", {61'd0, out_flags[5:3]}, 64'd0);
        check("R10", "out_undef", {63'd0, out_undef}, {63'd0, m_und});
        check("R11", "out_flags_we", {63'd0, out_flags_we}, {63'd0, m_we});
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] pat;
        pat = 64'hF0E1_D2C3_B4A5_9687;
        #1;
        step("R1", 1'b1, pat, 64'd4, 1'b1, 1'b1, 1'b0);
        step("R1", 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        step("R1", 1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
        // R3 narrow and wide masking
        step("R3", 1'b1, pat, 64'd0, 1'b0, 1'b0, 1'b0);
        step("R3", 1'b1, pat, 64'd12, 1'b0, 1'b0, 1'b0);
        step("R3", 1'b1, pat, 64'd31, 1'b1, 1'b0, 1'b0);
        step("R3", 1'b1, pat, 64'd40, 1'b1, 1'b1, 1'b0);
        step("R7", 1'b1, pat, 64'd63, 1'b1, 1'b1, 1'b0);
        // R4 saturation at the boundary and beyond
        step("R4", 1'b1, pat, 64'd32, 1'b0, 1'b0, 1'b0);
        step("R4", 1'b1, pat, 64'd64, 1'b1, 1'b1, 1'b0);
        step("R4", 1'b1, pat, 64'd255, 1'b1, 1'b1, 1'b0);
        // R2 upper index bits ignored
        step("R2", 1'b1, pat, 64'hFFFF_FFFF_FFFF_FF05, 1'b1, 1'b1, 1'b0);
        step("R2", 1'b1, pat, 64'h0000_0100_0000_0100, 1'b1, 1'b1, 1'b0);
        // R5 size select ignored outside long mode; R6 upper half zero
        step("R5", 1'b1, pat, 64'd48, 1'b0, 1'b1, 1'b0);
        step("R6", 1'b1, pat, 64'd200, 1'b1, 1'b0, 1'b0);
        // R7 zero result and sign at 32 bits
        step("R7", 1'b1, 64'hFFFF_FFFF_0000_0000, 64'd40, 1'b0, 1'b0, 1'b0);
        step("R7", 1'b1, 64'h0000_0000_8000_0000, 64'd32, 1'b1, 1'b0, 1'b0);
        // R10 undefined keeps state; R9 idle holds
        step("R10", 1'b1, 64'h1234, 64'd3, 1'b1, 1'b1, 1'b1);
        step("R9", 1'b0, 64'hFFFF, 64'd9, 1'b1, 1'b1, 1'b0);
        step("R10", 1'b1, '1, 64'd0, 1'b0, 1'b0, 1'b1);
        step("R11", 1'b1, '1, 64'd7, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 400; k++) begin
            logic [63:0] s;
            logic [63:0] ix;
            s  = {$urandom, $urandom};
            ix = {$urandom, $urandom};
            if (($urandom % 3) != 0) ix[7:0] = 8'($urandom % 70);
            step("R3", 1'($urandom % 5 != 0), s, ix, 1'($urandom), 1'($urandom),
                 1'($urandom % 8 == 0));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule